// File: doc/BRIEF.md
# Serial EEPROM Byte-Read Controller

This block is a bus master for a small serial EEPROM with an 8-bit address, of the kind that holds a network adapter's station address. It drives active-low chip select, serial clock and master-out data, and samples the memory's serial output. A requester pulses `start_i` with a first offset and a byte count. The block fetches that many bytes and returns each one on `rd_data_o` with a one-cycle `rd_valid_o` strobe. A one-cycle `done_o` pulse marks the end of the request. With `status_i` set, the block instead reads the memory's status byte.

Each byte is a complete transaction of its own. The block selects the device, sends the read opcode and the address, clocks in one byte and deselects. The next byte follows at offset plus one after an idle gap. Every level of the serial clock is held for `HALF_CYC` system cycles, so the bus speed can be set to suit slow parts. Once after reset, before the first transaction, the clock is pulsed with the device deselected to wake it.

Top module: `seeprom_rd_ctrl`

## Requirements
- R1: During and directly after synchronous reset, `spi_cs_n_o`=1, `spi_sck_o`=0, `spi_mosi_o`=0, `busy_o`=0, `rd_valid_o`=0 and `done_o`=0.
- R2: Before the first transaction after reset, the clock goes high exactly `WAKE_PULSES` times while `spi_cs_n_o` is high. Later requests send no such pulses.
- R3: A read transaction lowers `spi_cs_n_o` while `spi_sck_o` is low. On the rising clock edges it then presents opcode 0x03 MSB first, then the 8-bit address MSB first, then 8 more clocks for data: 24 rising edges in all.
- R4: While `spi_cs_n_o` is low and `spi_sck_o` is high, `spi_mosi_o` does not change. The line only changes in the low phase.
- R5: Each data bit is taken from `spi_miso_i` during the clock-high phase, first bit into the MSB. The byte appears on `rd_data_o` with `rd_valid_o` high for exactly one cycle, before the next transaction starts.
- R6: A request for N bytes at offset A performs N transactions, at addresses A, A+1, ... in that order, and returns N bytes in that order. After the last byte, `done_o` pulses for one cycle and `busy_o` then falls.
- R7: The address is 8 bits and wraps from 0xFF to 0x00.
- R8: Inside a transaction each clock level lasts `HALF_CYC` cycles, so rising edges are `2*HALF_CYC` cycles apart.
- R9: Between two transactions of one request, `spi_cs_n_o` stays high for exactly `HALF_CYC+GAP_CYC` cycles.
- R10: With `status_i`=1 the block performs a single transaction: opcode 0x05 MSB first, no address, and 8 data clocks (16 rising edges). The status byte is returned with one `rd_valid_o`, and the count input is ignored.
- R11: A read request with count 0 raises `done_o` in the cycle after it is accepted, and `spi_cs_n_o` never goes low.
- R12: A `start_i` pulse while `busy_o` is high is ignored. The request in progress finishes unchanged, and no further transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| status_i | input | 1 | 1: read status byte, 0: read data bytes |
| offset_i | input | ADDR_W | First EEPROM address |
| count_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| rd_data_o | output | DATA_W | Returned byte |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the EEPROM |
| spi_miso_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with `HALF_CYC`=3, `GAP_CYC`=5 and `WAKE_PULSES`=2, in place of the microsecond-scale defaults. A whole byte then takes about 155 cycles, so a wrap across address 0xFF and a start pulse aimed at a live transfer both fit in a short run. The small odd half-period keeps the exact edge spacing and the cs-high gap, 6 and 8 cycles, distinct from one another and from off-by-one variants. The two wake pulses are counted against the first request and against the later ones.

// File: rtl/seeprom_pkg.sv
// Shared definitions for the serial EEPROM read controller.
// Assumes an 8-bit opcode field on the serial bus.
package seeprom_pkg;

    // Sequencer states; the pin levels are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a request
        ST_WAKE,    // deselected clock pulses after reset
        ST_SEL,     // chip selected, clock low, settle
        ST_BLO,     // clock-low phase of one bit
        ST_BHI,     // clock-high phase of one bit
        ST_END,     // deselect after the last bit
        ST_GAP,     // idle spacing between transactions
        ST_DONE     // one-cycle completion
    } seq_state_t;

    localparam int          OPC_W      = 8;
    localparam logic [7:0]  OPC_READ   = 8'h03;
    localparam logic [7:0]  OPC_STATUS = 8'h05;

endpackage

// File: rtl/seeprom_pace.sv
// Phase timer: one down-counter that every sequencer state uses to
// time its length. A load of HALF_CYC or GAP_CYC makes the state last
// exactly that many cycles; expired_o is high in its final cycle.
// Assumes HALF_CYC >= 1 and GAP_CYC >= 1.
module seeprom_pace #(
    parameter int HALF_CYC = 1250,
    parameter int GAP_CYC  = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_half_i,
    input  logic load_gap_i,
    output logic expired_o
);
    localparam int MAXV = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
    localparam int CW   = (MAXV > 1) ? $clog2(MAXV + 1) : 1;
    localparam logic [CW-1:0] HALF_LD = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Reload on a state change, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_gap_i) begin
            cnt_q <= GAP_LD;
        end else if (load_half_i) begin
            cnt_q <= HALF_LD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/seeprom_shift.sv
// Serial shift paths: a transmit word (opcode plus address) shifted out
// MSB first, and a receive register filled MSB first. Each path also
// exposes its next value so that the pins can be driven from registers.
module seeprom_shift #(
    parameter int TX_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TX_W-1:0]   load_word_i,
    input  logic              tx_shift_i,
    input  logic              rx_shift_i,
    input  logic              miso_i,
    output logic              tx_msb_next_o,
    output logic [DATA_W-1:0] rx_next_o
);
    logic [TX_W-1:0]   tx_q, tx_d;
    logic [DATA_W-1:0] rx_q, rx_d;

    // Next transmit word: a fresh load, or a shift with zero fill.
    always_comb begin
        tx_d = tx_q;
        if (load_i) begin
            tx_d = load_word_i;
        end else if (tx_shift_i) begin
            tx_d = {tx_q[TX_W-2:0], 1'b0};
        end
    end

    // Next receive byte: cleared per transaction, MSB-first fill.
    always_comb begin
        rx_d = rx_q;
        if (load_i) begin
            rx_d = '0;
        end else if (rx_shift_i) begin
            rx_d = {rx_q[DATA_W-2:0], miso_i};
        end
    end

    // Register both shift paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign tx_msb_next_o = tx_d[TX_W-1];
    assign rx_next_o     = rx_d;

endmodule

// File: rtl/seeprom_track.sv
// Request bookkeeping: the current EEPROM address and the number of
// bytes still to fetch. The address wraps at the top of its range.
module seeprom_track #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;

    // Latch a new request, or advance one byte after a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (accept_i) begin
            addr_q <= offset_i;
            left_q <= count_i;
        end else if (step_i) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign last_o = (left_q == CNT_W'(1));

endmodule

// File: rtl/seeprom_rd_ctrl.sv
// Serial EEPROM byte-read controller (top).
// Fetches count_i bytes from offset_i, one select/opcode/address/data
// transaction per byte, or a single status byte when status_i is set.
// Pins are registered and decoded from the next sequencer state.
// Assumes spi_miso_i is stable across each clock-high phase.
module seeprom_rd_ctrl
    import seeprom_pkg::*;
#(
    parameter int HALF_CYC    = 1250,
    parameter int GAP_CYC     = 1250,
    parameter int WAKE_PULSES = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              status_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              spi_cs_n_o,
    output logic              spi_sck_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i
);
    localparam int TX_W    = OPC_W + ADDR_W;
    localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int WAKE_W  = (2 * WAKE_PULSES > 2) ? $clog2(2 * WAKE_PULSES) : 1;
    localparam logic [WAKE_W-1:0] WAKE_LAST   = WAKE_W'(2 * WAKE_PULSES - 1);
    localparam logic [BIT_W-1:0]  RD_FIRST    = BIT_W'(OPC_W + ADDR_W);
    localparam logic [BIT_W-1:0]  RD_LAST     = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0]  ST_FIRST    = BIT_W'(OPC_W);
    localparam logic [BIT_W-1:0]  ST_LAST     = BIT_W'(OPC_W + DATA_W - 1);

    seq_state_t        state_q, state_d;
    logic [WAKE_W-1:0] wake_idx_q, wake_idx_d;
    logic [BIT_W-1:0]  bit_idx_q;
    logic              woken_q;
    logic              op_status_q;

    logic              load_half, load_gap, expired;
    logic              accept, wake_adv, set_woken;
    logic              tx_load, tx_shift, rx_shift, bit_adv, emit, step;
    logic [ADDR_W-1:0] cur_addr;
    logic              last_byte;
    logic [TX_W-1:0]   tx_word;
    logic              tx_msb_next;
    logic [DATA_W-1:0] rx_next;
    logic [BIT_W-1:0]  first_data, last_bit;

    logic              cs_n_q, sck_q, mosi_q, valid_q, done_q;
    logic [DATA_W-1:0] data_q;

    seeprom_pace #(
        .HALF_CYC (HALF_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_pace (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_half_i (load_half),
        .load_gap_i  (load_gap),
        .expired_o   (expired)
    );

    seeprom_track #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .offset_i (offset_i),
        .count_i  (count_i),
        .step_i   (step),
        .addr_o   (cur_addr),
        .last_o   (last_byte)
    );

    seeprom_shift #(
        .TX_W   (TX_W),
        .DATA_W (DATA_W)
    ) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (tx_load),
        .load_word_i   (tx_word),
        .tx_shift_i    (tx_shift),
        .rx_shift_i    (rx_shift),
        .miso_i        (spi_miso_i),
        .tx_msb_next_o (tx_msb_next),
        .rx_next_o     (rx_next)
    );

    // Frame shape for the operation in progress.
    always_comb begin
        first_data = op_status_q ? ST_FIRST : RD_FIRST;
        last_bit   = op_status_q ? ST_LAST  : RD_LAST;
        tx_word    = op_status_q ? {OPC_STATUS, {ADDR_W{1'b0}}}
                                 : {OPC_READ, cur_addr};
    end

    // Sequencer next state and per-transition strobes.
    always_comb begin
        state_d   = state_q;
        load_half = 1'b0;
        load_gap  = 1'b0;
        accept    = 1'b0;
        wake_adv  = 1'b0;
        set_woken = 1'b0;
        tx_load   = 1'b0;
        tx_shift  = 1'b0;
        rx_shift  = 1'b0;
        bit_adv   = 1'b0;
        emit      = 1'b0;
        step      = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept = 1'b1;
                    if (!status_i && (count_i == '0)) begin
                        state_d = ST_DONE;
                    end else if (!woken_q) begin
                        state_d   = ST_WAKE;
                        load_half = 1'b1;
                    end else begin
                        state_d   = ST_SEL;
                        load_half = 1'b1;
                    end
                end
            end
            ST_WAKE: begin
                if (expired) begin
                    load_half = 1'b1;
                    if (wake_idx_q == WAKE_LAST) begin
                        set_woken = 1'b1;
                        state_d   = ST_SEL;
                    end else begin
                        wake_adv = 1'b1;
                    end
                end
            end
            ST_SEL: begin
                if (expired) begin
                    tx_load   = 1'b1;
                    load_half = 1'b1;
                    state_d   = ST_BLO;
                end
            end
            ST_BLO: begin
                if (expired) begin
                    load_half = 1'b1;
                    state_d   = ST_BHI;
                end
            end
            ST_BHI: begin
                if (expired) begin
                    tx_shift  = 1'b1;
                    rx_shift  = (bit_idx_q >= first_data);
                    load_half = 1'b1;
                    if (bit_idx_q == last_bit) begin
                        emit    = 1'b1;
                        state_d = ST_END;
                    end else begin
                        bit_adv = 1'b1;
                        state_d = ST_BLO;
                    end
                end
            end
            ST_END: begin
                if (expired) begin
                    if (op_status_q || last_byte) begin
                        state_d = ST_DONE;
                    end else begin
                        step     = 1'b1;
                        load_gap = 1'b1;
                        state_d  = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (expired) begin
                    load_half = 1'b1;
                    state_d   = ST_SEL;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Next wake-pulse phase index.
    always_comb begin
        wake_idx_d = wake_idx_q;
        if (accept) begin
            wake_idx_d = '0;
        end else if (wake_adv) begin
            wake_idx_d = wake_idx_q + 1'b1;
        end
    end

    // Sequencer state, counters and request flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wake_idx_q  <= '0;
            bit_idx_q   <= '0;
            woken_q     <= 1'b0;
            op_status_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            wake_idx_q <= wake_idx_d;
            if (accept) begin
                op_status_q <= status_i;
            end
            if (set_woken) begin
                woken_q <= 1'b1;
            end
            if (tx_load) begin
                bit_idx_q <= '0;
            end else if (bit_adv) begin
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // Registered pins decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            cs_n_q <= !((state_d == ST_SEL) || (state_d == ST_BLO) ||
                        (state_d == ST_BHI));
            sck_q  <= (state_d == ST_BHI) ||
                      ((state_d == ST_WAKE) && !wake_idx_d[0]);
            mosi_q <= ((state_d == ST_BLO) || (state_d == ST_BHI)) &&
                      tx_msb_next;
        end
    end

    // Byte strobe and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= emit;
            done_q  <= (state_d == ST_DONE);
            if (emit) begin
                data_q <= rx_next;
            end
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;
    assign spi_cs_n_o = cs_n_q;
    assign spi_sck_o  = sck_q;
    assign spi_mosi_o = mosi_q;

endmodule

// File: rtl/seeprom_rd_ctrl_chk.sv
// Protocol checker for seeprom_rd_ctrl, attached with bind.
// Observes only the top-level ports.
module seeprom_rd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic rd_valid_o,
    input logic spi_cs_n_o,
    input logic spi_sck_o,
    input logic spi_mosi_o
);
    // R1: reset leaves the pins and handshakes quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (spi_cs_n_o && !spi_sck_o && !spi_mosi_o &&
                    !busy_o && !rd_valid_o && !done_o));

    // R3: select only falls while the clock is low.
    a_r3_select_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n_o) |-> !spi_sck_o);

    // R4: data line holds through a selected clock-high phase.
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n_o && spi_sck_o) |=> (!spi_sck_o || $stable(spi_mosi_o)));

    // R5: byte strobe is a single cycle.
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    // R6: completion is a single cycle and ends the busy period.
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o ##1 (!busy_o && !done_o)));

    // R11: no bus selection while idle.
    a_r11_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> spi_cs_n_o);

    // R12: once busy, busy persists until completion.
    a_r12_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

bind seeprom_rd_ctrl seeprom_rd_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_valid_o (rd_valid_o),
    .spi_cs_n_o (spi_cs_n_o),
    .spi_sck_o  (spi_sck_o),
    .spi_mosi_o (spi_mosi_o)
);

// File: tb/seeprom_rd_ctrl_tb.sv
// Directed bench for seeprom_rd_ctrl with a behavioural EEPROM model.
module seeprom_rd_ctrl_tb;
    localparam int HALF = 3;
    localparam int GAP  = 5;
    localparam int WAKE = 2;
    localparam logic [7:0] STATUS_VAL = 8'h8C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       status_i = 1'b0;
    logic [7:0] offset_i = '0;
    logic [8:0] count_i = '0;
    logic       busy_o, done_o, rd_valid_o;
    logic [7:0] rd_data_o;
    logic       spi_cs_n_o, spi_sck_o, spi_mosi_o;
    logic       spi_miso_i = 1'b0;

    always #2 clk = ~clk;

    seeprom_rd_ctrl #(
        .HALF_CYC    (HALF),
        .GAP_CYC     (GAP),
        .WAKE_PULSES (WAKE),
        .ADDR_W      (8),
        .DATA_W      (8),
        .CNT_W       (9)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .status_i   (status_i),
        .offset_i   (offset_i),
        .count_i    (count_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .spi_cs_n_o (spi_cs_n_o),
        .spi_sck_o  (spi_sck_o),
        .spi_mosi_o (spi_mosi_o),
        .spi_miso_i (spi_miso_i)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    function automatic logic [7:0] memv(input logic [7:0] a);
        return (a * 8'd29) ^ 8'hC3;
    endfunction

    // EEPROM model and bus monitors
    logic [7:0] m_sh = '0, m_cmd = '0, m_addr = '0;
    int m_bits = 0;
    int txn_cnt = 0, wake_rises = 0, proto_err = 0;
    logic [7:0] cmd_log [16];
    logic [7:0] addr_log [16];
    int bits_log [16];
    int last_rise = -1, rise_min = 1000, rise_max = 0;
    int cs_rise_cyc = 0, last_gap = 0;
    logic sck_p = 1'b0, cs_p = 1'b1, mosi_p = 1'b0;
    logic [7:0] rx_buf [64];
    int rx_n = 0, done_n = 0, valid_dbl = 0, done_dbl = 0;
    logic valid_p = 1'b0, done_p = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (cs_p && !spi_cs_n_o) begin
                if (txn_cnt > 0) last_gap = cyc - cs_rise_cyc;
                txn_cnt = txn_cnt + 1;
                m_bits = 0; m_cmd = '0; m_sh = '0; last_rise = -1;
            end
            if (!cs_p && spi_cs_n_o) begin
                bits_log[(txn_cnt - 1) % 16] = m_bits;
                cs_rise_cyc = cyc;
            end
            if (!sck_p && spi_sck_o) begin
                if (spi_cs_n_o) begin
                    wake_rises = wake_rises + 1;
                end else begin
                    m_sh = {m_sh[6:0], spi_mosi_o};
                    m_bits = m_bits + 1;
                    if (m_bits == 8) begin
                        m_cmd = m_sh;
                        cmd_log[(txn_cnt - 1) % 16] = m_sh;
                    end
                    if (m_bits == 16) begin
                        m_addr = m_sh;
                        addr_log[(txn_cnt - 1) % 16] = m_sh;
                    end
                    if (last_rise >= 0) begin
                        if (cyc - last_rise < rise_min) rise_min = cyc - last_rise;
                        if (cyc - last_rise > rise_max) rise_max = cyc - last_rise;
                    end
                    last_rise = cyc;
                end
            end
            if (sck_p && !spi_sck_o && !spi_cs_n_o) begin
                if (m_cmd == 8'h03 && m_bits >= 16 && m_bits < 24)
                    spi_miso_i = memv(m_addr)[23 - m_bits];
                else if (m_cmd == 8'h05 && m_bits >= 8 && m_bits < 16)
                    spi_miso_i = STATUS_VAL[15 - m_bits];
                else
                    spi_miso_i = 1'b0;
            end
            if (!spi_cs_n_o && spi_sck_o && sck_p && (spi_mosi_o != mosi_p))
                proto_err = proto_err + 1;
            if (rd_valid_o) begin
                if (rx_n < 64) rx_buf[rx_n] = rd_data_o;
                rx_n = rx_n + 1;
            end
            if (rd_valid_o && valid_p) valid_dbl = valid_dbl + 1;
            if (done_o) done_n = done_n + 1;
            if (done_o && done_p) done_dbl = done_dbl + 1;
        end
        sck_p = spi_sck_o; cs_p = spi_cs_n_o; mosi_p = spi_mosi_o;
        valid_p = rd_valid_o; done_p = done_o;
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic st, input logic [7:0] off, input int cnt);
        @(negedge clk);
        start_i = 1'b1; status_i = st; offset_i = off; count_i = 9'(cnt);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int base);
        for (int i = 0; i < 20000 && done_n == base; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cs_n", int'(spi_cs_n_o), 1);
        check("R1 sck", int'(spi_sck_o), 0);
        check("R1 mosi", int'(spi_mosi_o), 0);
        check("R1 busy/valid/done", int'({busy_o, rd_valid_o, done_o}), 0);
    endtask

    task automatic t_first_read();
        int d0 = done_n, r0 = rx_n, t0 = txn_cnt;
        check("R2 no pulses before request", wake_rises, 0);
        pulse_start(1'b0, 8'h10, 1);
        wait_done(d0);
        check("R2 wake pulses", wake_rises, WAKE);
        check("R3 one transaction", txn_cnt - t0, 1);
        check("R3 opcode", int'(cmd_log[t0 % 16]), 8'h03);
        check("R3 address", int'(addr_log[t0 % 16]), 8'h10);
        check("R3 clock count", bits_log[t0 % 16], 24);
        check("R5 byte count", rx_n - r0, 1);
        check("R5 byte value", int'(rx_buf[r0]), int'(memv(8'h10)));
        check("R8 min edge spacing", rise_min, 2 * HALF);
        check("R8 max edge spacing", rise_max, 2 * HALF);
        @(negedge clk);
        check("R6 busy low after done", int'(busy_o), 0);
    endtask

    task automatic t_multi();
        int d0 = done_n, r0 = rx_n, t0 = txn_cnt;
        pulse_start(1'b0, 8'h20, 4);
        wait_done(d0);
        check("R6 transactions", txn_cnt - t0, 4);
        check("R6 bytes", rx_n - r0, 4);
        for (int k = 0; k < 4; k++) begin
            check("R6 address order", int'(addr_log[(t0 + k) % 16]), 8'h20 + k);
            check("R6 byte order", int'(rx_buf[r0 + k]), int'(memv(8'(8'h20 + k))));
        end
        check("R9 deselect gap", last_gap, HALF + GAP);
        check("R2 no further wake pulses", wake_rises, WAKE);
    endtask

    task automatic t_wrap();
        int d0 = done_n, r0 = rx_n, t0 = txn_cnt;
        pulse_start(1'b0, 8'hFE, 3);
        wait_done(d0);
        check("R7 addr FE", int'(addr_log[t0 % 16]), 8'hFE);
        check("R7 addr FF", int'(addr_log[(t0 + 1) % 16]), 8'hFF);
        check("R7 addr 00", int'(addr_log[(t0 + 2) % 16]), 8'h00);
        check("R7 byte at 00", int'(rx_buf[r0 + 2]), int'(memv(8'h00)));
    endtask

    task automatic t_status();
        int d0 = done_n, r0 = rx_n, t0 = txn_cnt;
        pulse_start(1'b1, 8'h33, 5);
        wait_done(d0);
        check("R10 one transaction", txn_cnt - t0, 1);
        check("R10 opcode", int'(cmd_log[t0 % 16]), 8'h05);
        check("R10 clock count", bits_log[t0 % 16], 16);
        check("R10 one byte", rx_n - r0, 1);
        check("R10 status value", int'(rx_buf[r0]), int'(STATUS_VAL));
    endtask

    task automatic t_zero();
        int t0 = txn_cnt, r0 = rx_n;
        @(negedge clk);
        start_i = 1'b1; status_i = 1'b0; offset_i = 8'h50; count_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        check("R11 done next cycle", int'(done_o), 1);
        repeat (20) @(negedge clk);
        check("R11 no transaction", txn_cnt - t0, 0);
        check("R11 no byte", rx_n - r0, 0);
    endtask

    task automatic t_busy();
        int d0 = done_n, r0 = rx_n, t0 = txn_cnt;
        pulse_start(1'b0, 8'h40, 2);
        repeat (40) @(negedge clk);
        pulse_start(1'b1, 8'h80, 1);
        wait_done(d0);
        check("R12 transactions", txn_cnt - t0, 2);
        check("R12 first byte", int'(rx_buf[r0]), int'(memv(8'h40)));
        check("R12 second byte", int'(rx_buf[r0 + 1]), int'(memv(8'h41)));
        check("R12 opcode kept", int'(cmd_log[(t0 + 1) % 16]), 8'h03);
        repeat (200) @(negedge clk);
        check("R12 nothing queued", txn_cnt - t0, 2);
        check("R12 idle", int'(busy_o), 0);
    endtask

    always @(negedge clk) begin
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_first_read();
        t_multi();
        t_wrap();
        t_status();
        t_zero();
        t_busy();
        check("R4 mosi changes while high", proto_err, 0);
        check("R5 valid wider than one", valid_dbl, 0);
        check("R6 done wider than one", done_dbl, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule